// File: doc/BRIEF.md
# Receive Descriptor Queue Engine

This block moves received frames into memory buffers described by a chain of descriptors. Each descriptor occupies four consecutive 32-bit words at a word address: offset 0 holds the link to the following descriptor (zero ends the chain), offset 1 the word address of the data buffer, offset 2 the buffer size in bytes, and offset 3 a status word. Software builds the chain, sets the owner bit in each status word, and starts the engine by writing the address of the first descriptor. The engine keeps its own pointer to the current descriptor and moves it along the chain as each descriptor is filled. It never needs to know how long the chain is.

Frames arrive as a byte stream with start and end markers. The engine packs the bytes into words and stores them in the current buffer. When the buffer is full or the frame ends, it reads the link word again, writes the status word back with the owner bit cleared, and moves to the next descriptor. Software may lengthen a running chain by writing into the zero link of its last descriptor. When the engine closes a descriptor whose link still reads zero, it marks that descriptor as the end of the queue and stops. A free-buffer count, compared with a threshold, drives a pause request. A completion pointer reports the most recent descriptor written back.

Top module: `rxq_engine`

## Requirements
- R1: A write to the head pointer while the engine is active is ignored, and `hdp_err` is high in the following cycle. A nonzero write while idle starts the engine at that descriptor. A zero write while idle is ignored and raises no error.
- R2: The link word of a descriptor is read from memory when that descriptor is closed, not when it is first fetched, so a link patched after the fetch is followed.
- R3: Status bit 28 (end of queue) is set when the link read at close is zero. The engine then goes idle with `cur_ptr` equal to zero.
- R4: Every status write-back has bit 29 (owner) clear. A descriptor that has been written back is not read or written again until software links it in again.
- R5: After each write-back with a nonzero link, `cur_ptr` takes the value of that link.
- R6: `free_cnt` rises by `fb_add_val` on each `fb_add_wr` and falls by one for each descriptor written back. It does not go below zero.
- R7: `pause` is high exactly while `free_cnt` is at or below `flow_thresh`.
- R8: The status word carries the start-of-frame flag in bit 31, the end-of-frame flag in bit 30, and the number of bytes stored in that descriptor in bits 15:0. All other bits are zero.
- R9: A frame is dropped, and `drop_cnt` is incremented, if it starts while the engine is idle, or if it starts on a descriptor whose owner bit is clear. A dropped frame writes nothing to memory. While the owner bit is clear, the engine re-reads that status word until software sets it.
- R10: A frame longer than a buffer continues in the next linked descriptor. Only the first descriptor of the frame carries bit 31, and only the last carries bit 30. If the chain ends in the middle of a frame, the rest of the frame is dropped and counted.
- R11: `cpl_ptr` holds the address of the last descriptor written back, and `cpl_pend` goes high with it. A `cpl_ack_wr` whose value equals `cpl_ptr` clears `cpl_pend`. Any other value leaves it set.
- R12: Byte k of a descriptor is stored in buffer word k/4, in byte lane k mod 4 (lane 0 in bits 7:0). The unused lanes of the final word are zero. Buffer sizes are multiples of four bytes.
- R13: The memory request, address and write enable stay stable until `mem_rdy` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdp_wr | input | 1 | Head pointer write strobe |
| hdp_val | input | AW | Head descriptor address |
| hdp_err | output | 1 | Rejected head write, one cycle |
| active | output | 1 | Engine owns a descriptor chain |
| cur_ptr | output | AW | Current descriptor address (zero when idle) |
| rx_valid | input | 1 | Byte valid |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_ready | output | 1 | Byte accepted on this edge when valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory accepts or completes the request |
| fb_add_wr | input | 1 | Free-buffer increment strobe |
| fb_add_val | input | CW | Amount added to the free count |
| flow_thresh | input | CW | Pause threshold |
| free_cnt | output | CW | Free-buffer count |
| pause | output | 1 | Pause request |
| cpl_ack_wr | input | 1 | Completion acknowledge strobe |
| cpl_ack_val | input | AW | Descriptor address being acknowledged |
| cpl_ptr | output | AW | Last descriptor written back |
| cpl_pend | output | 1 | Completion not yet acknowledged |
| drop_cnt | output | CW | Dropped frame count |

## Verification
The assertions check the following on every cycle:
- head writes are rejected while the engine is active;
- the pointer is zero whenever the engine is idle;
- every status write-back has the owner bit clear;
- the engine goes idle after an end-of-queue write-back;
- the free count falls on each write-back;
- the pause level follows the count;
- memory requests stay stable while the port stalls.

Some behaviour can only be shown by the bench scenarios: a link patched after the descriptor was fetched, byte packing across a buffer boundary, the start and end flags on a frame split over two descriptors, the drop cases for an idle engine and for a descriptor that software has not released, and acknowledgement of the completion pointer.

// File: rtl/rxq_pkg.sv
// Shared definitions for the receive descriptor queue engine.
// Assumes 32-bit memory words and a four-word descriptor record.
package rxq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_FLG, ST_RD_BUF, ST_RD_LEN, ST_RDY,
        ST_WR_DAT, ST_RD_NXT, ST_WR_FLG, ST_DROP
    } rxq_state_e;

    localparam int unsigned OFS_LINK = 0;
    localparam int unsigned OFS_BUF  = 1;
    localparam int unsigned OFS_SIZE = 2;
    localparam int unsigned OFS_STAT = 3;

    localparam int unsigned BIT_SOF = 31;
    localparam int unsigned BIT_EOF = 30;
    localparam int unsigned BIT_OWN = 29;
    localparam int unsigned BIT_EOQ = 28;

    // Builds a write-back status word; the owner bit is always left clear.
    function automatic logic [31:0] make_status(input logic sof, input logic eof,
                                                input logic eoq, input logic [15:0] len);
        logic [31:0] s;
        s = '0;
        s[BIT_SOF] = sof;
        s[BIT_EOF] = eof;
        s[BIT_EOQ] = eoq;
        s[15:0]    = len;
        return s;
    endfunction
endpackage

// File: rtl/rxq_flow.sv
// Free-buffer counter with threshold compare.
// Software adds buffers; each consumed descriptor removes one. Saturates at zero.
module rxq_flow #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_wr,
    input  logic [CW-1:0] add_val,
    input  logic          consume,
    input  logic [CW-1:0] thresh,
    output logic [CW-1:0] count,
    output logic          pause
);
    logic [CW-1:0] sum;

    // Sum of the current count and any software addition this cycle.
    always_comb sum = count + (add_wr ? add_val : '0);

    // Register the new count, removing one buffer per consumed descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (consume && sum != '0) count <= sum - CW'(1);
        else                           count <= sum;
    end

    // Pause request while the buffers are at or below the threshold.
    always_comb pause = (count <= thresh);
endmodule

// File: rtl/rxq_cpl.sv
// Completion pointer register with acknowledge.
// A write-back and an acknowledge in the same cycle: the write-back wins.
module rxq_cpl #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_pulse,
    input  logic [AW-1:0] wb_addr,
    input  logic          ack_wr,
    input  logic [AW-1:0] ack_val,
    output logic [AW-1:0] ptr,
    output logic          pend
);
    // Capture the latest write-back, or clear pending on a matching acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            pend <= 1'b0;
        end else if (wb_pulse) begin
            ptr  <= wb_addr;
            pend <= 1'b1;
        end else if (ack_wr && ack_val == ptr) begin
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_walker.sv
// Descriptor chain walker. It fetches the current descriptor, packs incoming
// bytes into buffer words, re-reads the link at close, writes the status back
// and advances. It stops at a zero link.
// Assumes buffer sizes are nonzero multiples of four bytes, and a memory port
// whose read data is valid in the cycle mem_rdy is high.
module rxq_walker
    import rxq_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned LW = 16,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hdp_wr,
    input  logic [AW-1:0] hdp_val,
    output logic          hdp_err,
    output logic          active,
    output logic [AW-1:0] cur_ptr,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    output logic          rx_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_rdy,
    output logic          wb_pulse,
    output logic [CW-1:0] drop_cnt
);
    localparam int unsigned LANEW = 2;

    rxq_state_e    st;
    logic [AW-1:0] cur, bufp, widx;
    logic [31:0]   link, acc;
    logic [LW-1:0] blen, bcnt;
    logic          own_ok, sof_r, eof_r, in_frame;
    logic [LANEW-1:0] lane;
    logic          take, unused_rd;

    assign unused_rd = ^mem_rdata;
    assign cur_ptr   = cur;
    assign active    = (st != ST_IDLE);
    assign lane      = bcnt[LANEW-1:0];
    assign take      = rx_valid && rx_ready;
    assign wb_pulse  = (st == ST_WR_FLG) && mem_rdy;

    // Byte acceptance depends only on the state, never on rx_valid.
    always_comb rx_ready = (st == ST_IDLE) || (st == ST_RDY) || (st == ST_DROP);

    // Drive the memory port from the current state.
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = '0;
        unique case (st)
            ST_RD_FLG: mem_addr = cur + AW'(OFS_STAT);
            ST_RD_BUF: mem_addr = cur + AW'(OFS_BUF);
            ST_RD_LEN: mem_addr = cur + AW'(OFS_SIZE);
            ST_RD_NXT: mem_addr = cur + AW'(OFS_LINK);
            ST_WR_DAT: begin
                mem_we    = 1'b1;
                mem_addr  = bufp + widx;
                mem_wdata = acc;
            end
            ST_WR_FLG: begin
                mem_we    = 1'b1;
                mem_addr  = cur + AW'(OFS_STAT);
                mem_wdata = make_status(sof_r, eof_r, link == '0, 16'(bcnt));
            end
            default: mem_req = 1'b0;
        endcase
    end

    // Reject a head write that arrives while the chain is active.
    always_ff @(posedge clk) begin
        if (!rst_n) hdp_err <= 1'b0;
        else        hdp_err <= hdp_wr && (st != ST_IDLE);
    end

    // Main sequencer: fetch, fill, close, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; cur <= '0; bufp <= '0; widx <= '0; link <= '0;
            acc <= '0; blen <= '0; bcnt <= '0; own_ok <= 1'b0;
            sof_r <= 1'b0; eof_r <= 1'b0; in_frame <= 1'b0; drop_cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (take && rx_sof) drop_cnt <= drop_cnt + CW'(1);
                    if (hdp_wr && hdp_val != '0) begin
                        cur      <= hdp_val;
                        in_frame <= 1'b0;
                        st       <= ST_RD_FLG;
                    end
                end
                ST_RD_FLG: if (mem_rdy) begin
                    own_ok <= mem_rdata[BIT_OWN];
                    if (mem_rdata[BIT_OWN]) st <= ST_RD_BUF;
                    else if (in_frame) begin
                        drop_cnt <= drop_cnt + CW'(1);
                        st       <= ST_DROP;
                    end else st <= ST_RDY;
                end
                ST_RD_BUF: if (mem_rdy) begin
                    bufp <= mem_rdata[AW-1:0];
                    st   <= ST_RD_LEN;
                end
                ST_RD_LEN: if (mem_rdy) begin
                    blen  <= mem_rdata[LW-1:0];
                    bcnt  <= '0;
                    widx  <= '0;
                    sof_r <= 1'b0;
                    eof_r <= 1'b0;
                    st    <= ST_RDY;
                end
                ST_RDY: begin
                    if (!own_ok) begin
                        if (take && rx_sof) begin
                            drop_cnt <= drop_cnt + CW'(1);
                            in_frame <= !rx_eof;
                            st       <= rx_eof ? ST_RD_FLG : ST_DROP;
                        end else st <= ST_RD_FLG;
                    end else if (take && (in_frame || rx_sof)) begin
                        if (rx_sof) sof_r <= 1'b1;
                        in_frame <= 1'b1;
                        acc  <= (lane == '0) ? {24'b0, rx_data}
                                             : acc | ({24'b0, rx_data} << (8 * lane));
                        bcnt <= bcnt + LW'(1);
                        eof_r <= rx_eof;
                        if (lane == '1 || rx_eof || bcnt + LW'(1) == blen) st <= ST_WR_DAT;
                    end
                end
                ST_WR_DAT: if (mem_rdy) begin
                    widx <= widx + AW'(1);
                    st   <= (eof_r || bcnt == blen) ? ST_RD_NXT : ST_RDY;
                end
                ST_RD_NXT: if (mem_rdy) begin
                    link <= mem_rdata;
                    st   <= ST_WR_FLG;
                end
                ST_WR_FLG: if (mem_rdy) begin
                    if (eof_r) in_frame <= 1'b0;
                    if (link == '0) begin
                        cur      <= '0;
                        in_frame <= 1'b0;
                        if (!eof_r) drop_cnt <= drop_cnt + CW'(1);
                        st <= ST_IDLE;
                    end else begin
                        cur <= link[AW-1:0];
                        st  <= ST_RD_FLG;
                    end
                end
                ST_DROP: if (take && rx_eof) begin
                    in_frame <= 1'b0;
                    st       <= (cur == '0) ? ST_IDLE : ST_RD_FLG;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxq_engine.sv
// Top of the receive descriptor queue engine. It ties the walker, the
// free-buffer flow control and the completion pointer together.
// Assumes the memory port and software share the descriptor words, and that
// software changes only zero links and released descriptors.
module rxq_engine #(
    parameter int unsigned AW = 16,
    parameter int unsigned LW = 16,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hdp_wr,
    input  logic [AW-1:0] hdp_val,
    output logic          hdp_err,
    output logic          active,
    output logic [AW-1:0] cur_ptr,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_sof,
    input  logic          rx_eof,
    output logic          rx_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_rdy,
    input  logic          fb_add_wr,
    input  logic [CW-1:0] fb_add_val,
    input  logic [CW-1:0] flow_thresh,
    output logic [CW-1:0] free_cnt,
    output logic          pause,
    input  logic          cpl_ack_wr,
    input  logic [AW-1:0] cpl_ack_val,
    output logic [AW-1:0] cpl_ptr,
    output logic          cpl_pend,
    output logic [CW-1:0] drop_cnt
);
    logic wb_pulse;

    rxq_walker #(.AW(AW), .LW(LW), .CW(CW)) u_walk (
        .clk(clk), .rst_n(rst_n), .hdp_wr(hdp_wr), .hdp_val(hdp_val),
        .hdp_err(hdp_err), .active(active), .cur_ptr(cur_ptr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .wb_pulse(wb_pulse), .drop_cnt(drop_cnt)
    );

    rxq_flow #(.CW(CW)) u_flow (
        .clk(clk), .rst_n(rst_n), .add_wr(fb_add_wr), .add_val(fb_add_val),
        .consume(wb_pulse), .thresh(flow_thresh), .count(free_cnt), .pause(pause)
    );

    rxq_cpl #(.AW(AW)) u_cpl (
        .clk(clk), .rst_n(rst_n), .wb_pulse(wb_pulse), .wb_addr(cur_ptr),
        .ack_wr(cpl_ack_wr), .ack_val(cpl_ack_val), .ptr(cpl_ptr), .pend(cpl_pend)
    );
endmodule

// File: rtl/rxq_engine_chk.sv
// Property checker for rxq_engine. It sees only the top-level ports.
module rxq_engine_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hdp_wr,
    input logic          hdp_err,
    input logic          active,
    input logic [AW-1:0] cur_ptr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_rdy,
    input logic          fb_add_wr,
    input logic [CW-1:0] free_cnt,
    input logic [CW-1:0] flow_thresh,
    input logic          pause
);
    logic stat_wr;
    assign stat_wr = mem_req && mem_we && (mem_addr == cur_ptr + AW'(3));

    AST_HEAD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (hdp_wr && active) |=> hdp_err);                                   // R1
    AST_IDLE_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (cur_ptr == '0));                                      // R3
    AST_EOQ_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && mem_rdy && mem_wdata[28]) |=> !active);                // R3
    AST_OWNER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |-> !mem_wdata[29]);                                       // R4
    AST_FREE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && mem_rdy && !fb_add_wr && free_cnt != '0)
        |=> (free_cnt == $past(free_cnt) - CW'(1)));                       // R6
    AST_PAUSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt <= flow_thresh) |-> pause);                              // R7
    AST_PAUSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt > flow_thresh) |-> !pause);                              // R7
    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13
endmodule

bind rxq_engine rxq_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .hdp_wr(hdp_wr), .hdp_err(hdp_err),
    .active(active), .cur_ptr(cur_ptr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdy(mem_rdy),
    .fb_add_wr(fb_add_wr), .free_cnt(free_cnt), .flow_thresh(flow_thresh),
    .pause(pause)
);

// File: tb/sim_rxq_engine.sv
module sim_rxq_engine;
    localparam int AW = 8;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hdp_wr = 1'b0;
    logic [AW-1:0] hdp_val = '0;
    logic hdp_err, active;
    logic [AW-1:0] cur_ptr;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_ready, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic mem_rdy = 1'b1;
    logic fb_add_wr = 1'b0;
    logic [CW-1:0] fb_add_val = '0;
    logic [CW-1:0] flow_thresh = 16'd1;
    logic [CW-1:0] free_cnt, drop_cnt;
    logic pause;
    logic cpl_ack_wr = 1'b0;
    logic [AW-1:0] cpl_ack_val = '0;
    logic [AW-1:0] cpl_ptr;
    logic cpl_pend;

    int tests = 0;
    int fails = 0;
    int pause_err = 0;
    int mfree = 0;
    logic [31:0] mem [0:255];
    logic sw_we = 1'b0;
    logic [AW-1:0] sw_addr = '0;
    logic [31:0] sw_data = '0;

    always #2 clk = ~clk;

    rxq_engine #(.AW(AW), .LW(16), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .hdp_wr(hdp_wr), .hdp_val(hdp_val),
        .hdp_err(hdp_err), .active(active), .cur_ptr(cur_ptr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rdy(mem_rdy), .fb_add_wr(fb_add_wr), .fb_add_val(fb_add_val),
        .flow_thresh(flow_thresh), .free_cnt(free_cnt), .pause(pause),
        .cpl_ack_wr(cpl_ack_wr), .cpl_ack_val(cpl_ack_val), .cpl_ptr(cpl_ptr),
        .cpl_pend(cpl_pend), .drop_cnt(drop_cnt)
    );

    assign mem_rdata = mem[mem_addr];

    // Memory model: engine writes and software writes, with a fill pattern at reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'hDEADBEEF;
        end else begin
            if (mem_req && mem_we && mem_rdy) mem[mem_addr] <= mem_wdata;
            if (sw_we) mem[sw_addr] <= sw_data;
        end
    end

    // Port stalls: every third cycle the memory is not ready.
    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rdy = (cyc % 3) != 0;
        end
    end

    // Reference free count. Descriptors live below 0x40, so a status write there is one consumed buffer.
    always @(posedge clk) begin
        int t;
        if (!rst_n) mfree <= 0;
        else begin
            t = mfree + (fb_add_wr ? int'(fb_add_val) : 0);
            if (mem_req && mem_we && mem_rdy && mem_addr[1:0] == 2'd3 && mem_addr < 8'h40 && t > 0) t--;
            mfree <= t;
        end
    end

    // Compare the pause level and the count with the reference on every clock.
    always @(negedge clk) begin
        if (rst_n && (pause !== (mfree <= int'(flow_thresh)) || int'(free_cnt) != mfree)) begin
            pause_err++;
            if (pause_err < 4)
                $display("FAIL R7 per-cycle pause=%0b free=%0d expected free=%0d", pause, free_cnt, mfree);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_addr = a; sw_data = d;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic set_desc(input logic [AW-1:0] d, input logic [31:0] lnk,
                            input logic [31:0] bp, input logic [31:0] sz, input logic [31:0] st);
        sw_write(d, lnk); sw_write(d + 1, bp); sw_write(d + 2, sz); sw_write(d + 3, st);
    endtask

    task automatic add_free(input int n);
        @(negedge clk);
        fb_add_wr = 1'b1; fb_add_val = CW'(n);
        @(negedge clk);
        fb_add_wr = 1'b0;
    endtask

    task automatic write_head(input logic [AW-1:0] a);
        @(negedge clk);
        hdp_wr = 1'b1; hdp_val = a;
        @(negedge clk);
        hdp_wr = 1'b0;
    endtask

    // Sends a frame of n bytes, byte i = base + i, honouring rx_ready.
    task automatic send_frame(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = base + 8'(i);
            rx_sof = (i == 0); rx_eof = (i == n - 1);
            while (!rx_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat (60) @(negedge clk);
    endtask

    function automatic logic [31:0] word_of(input logic [7:0] b);
        return {b + 8'd3, b + 8'd2, b + 8'd1, b};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        chk("R3 reset active", 32'(active), 32'd0);
        chk("R3 reset cur_ptr", 32'(cur_ptr), 32'd0);
        chk("R7 reset pause", 32'(pause), 32'd1);
        chk("R9 reset drop", 32'(drop_cnt), 32'd0);
        chk("R11 reset pend", 32'(cpl_pend), 32'd0);

        set_desc(8'h10, 32'h14, 32'h40, 32'd32, 32'h2000_0000);
        set_desc(8'h14, 32'h00, 32'h50, 32'd32, 32'h2000_0000);
        set_desc(8'h18, 32'h00, 32'h60, 32'd16, 32'h2000_0000);
        add_free(3);
        @(negedge clk);
        chk("R6 free after add", 32'(free_cnt), 32'd3);
        chk("R7 pause low", 32'(pause), 32'd0);

        // R9: frame while idle is dropped
        send_frame(5, 8'h90);
        chk("R9 idle drop count", 32'(drop_cnt), 32'd1);
        chk("R9 idle no write", mem[8'h13], 32'h2000_0000);

        // R1 arm, then single-descriptor frame (R8, R12, R5, R11)
        write_head(8'h10);
        chk("R1 armed active", 32'(active), 32'd1);
        send_frame(10, 8'hA0);
        chk("R12 word0", mem[8'h40], 32'hA3A2A1A0);
        chk("R12 word1", mem[8'h41], 32'hA7A6A5A4);
        chk("R12 tail zero", mem[8'h42], 32'h0000A9A8);
        chk("R8 status", mem[8'h13], 32'hC000_000A);
        chk("R4 owner clear", 32'(mem[8'h13][29]), 32'd0);
        chk("R5 advance", 32'(cur_ptr), 32'h14);
        chk("R11 cpl ptr", 32'(cpl_ptr), 32'h10);
        chk("R11 pend set", 32'(cpl_pend), 32'd1);
        chk("R6 free dec", 32'(free_cnt), 32'd2);

        // R1: head write while active rejected
        @(negedge clk);
        hdp_wr = 1'b1; hdp_val = 8'h1C;
        @(negedge clk);
        hdp_wr = 1'b0;
        chk("R1 error pulse", 32'(hdp_err), 32'd1);
        chk("R1 pointer kept", 32'(cur_ptr), 32'h14);

        // R2 late link patch, R10 frame spans two descriptors, R3 end of queue
        sw_write(8'h14, 32'h18);
        send_frame(40, 8'h00);
        chk("R10 first buf word", mem[8'h50], 32'h03020100);
        chk("R10 last buf word", mem[8'h57], word_of(8'h1C));
        chk("R10 first status", mem[8'h17], 32'h8000_0020);
        chk("R2 followed patched link", mem[8'h60], 32'h23222120);
        chk("R12 second desc word", mem[8'h61], 32'h27262524);
        chk("R3 eoq status", mem[8'h1B], 32'h5000_0008);
        chk("R3 idle", 32'(active), 32'd0);
        chk("R3 head zero", 32'(cur_ptr), 32'd0);
        chk("R7 pause at zero", 32'(pause), 32'd1);
        chk("R11 cpl last", 32'(cpl_ptr), 32'h18);

        // R11 acknowledge
        @(negedge clk); cpl_ack_wr = 1'b1; cpl_ack_val = 8'h14;
        @(negedge clk); cpl_ack_wr = 1'b0;
        chk("R11 wrong ack keeps pend", 32'(cpl_pend), 32'd1);
        @(negedge clk); cpl_ack_wr = 1'b1; cpl_ack_val = 8'h18;
        @(negedge clk); cpl_ack_wr = 1'b0;
        chk("R11 ack clears", 32'(cpl_pend), 32'd0);

        // R9 descriptor not released by software
        set_desc(8'h1C, 32'h00, 32'h70, 32'd16, 32'h0000_0000);
        write_head(8'h1C);
        chk("R1 idle write no error", 32'(hdp_err), 32'd0);
        send_frame(3, 8'h55);
        chk("R9 owner drop count", 32'(drop_cnt), 32'd2);
        chk("R9 owner no write", mem[8'h70], 32'hDEADBEEF);
        chk("R9 status untouched", mem[8'h1F], 32'h0000_0000);

        // Release it, then a frame lands there
        sw_write(8'h1F, 32'h2000_0000);
        add_free(1);
        repeat (20) @(negedge clk);
        chk("R7 pause at threshold", 32'(pause), 32'd1);
        send_frame(4, 8'h11);
        chk("R12 released desc data", mem[8'h70], 32'h14131211);
        chk("R8 released desc status", mem[8'h1F], 32'hD000_0004);
        chk("R6 free back to zero", 32'(free_cnt), 32'd0);
        chk("R3 stopped again", 32'(active), 32'd0);

        tests++;
        if (pause_err != 0) fails++;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule